// File: doc/BRIEF.md
# Link Bring-Up Configuration Sequencer

This block brings a pair of serial-link endpoints, a local one and its peer, from power-on to a programmed state without software. After system reset it drives a shared active-low endpoint reset for a fixed time. It then waits for both endpoints to report their port as initialized. Because a reset exchange on the link can briefly drop initialization, it waits out a settling interval and then demands both initialized indications a second time. Only after that does it start programming.

Programming is a fixed script of ten 32-bit register writes. Four go to the peer and six to the local endpoint, each through its own memory-mapped master port. The script sets device IDs, enables request generation, opens an I/O window and a maintenance window on the local side aimed at the peer, and enables the peer's receive window and interrupts. A parameter picks 8-bit or 16-bit device IDs, and this changes four of the data words. Back-pressure on each master port follows the usual memory-mapped rule. Once asserted, the write strobe, address and data stay unchanged while the target holds waitrequest high. The write completes in the first cycle where the strobe is high and waitrequest is low. A done flag marks the end of the script. An error flag marks an initialization wait that timed out.

Top module: `link_bringup_seq`

## Requirements
- R1: `ep_rst_n_o` is low throughout system reset. It stays low for ceil(RESET_NS*1000/CLK_PERIOD_PS) clock edges after `rst_n` is released (40 with the defaults), then goes high and stays high.
- R2: No write strobe rises until `loc_init_i` and `peer_init_i` are high in the same cycle. One of them alone does not advance the sequence.
- R3: Once both are first seen high, the block waits ceil(SETTLE_NS*1000/CLK_PERIOD_PS) cycles (1000 with the defaults) whatever the init inputs do. It then waits again until both are high before the first write.
- R4: The writes are accepted in this order, as (target, address): (local,0x00060) (local,0x0013C) (peer,0x00060) (peer,0x0013C) (local,0x1040C) (local,0x10404) (peer,0x10504) (peer,0x10304) (local,0x1010C) (local,0x10104).
- R5: With ID16=0 the data words in script order are 0x00AAFFFF, 0x60000000, 0x0055FFFF, 0x60000000, 0x00550000, 0x00000004, 0x0000000F, 0x00000004, 0x0055FF00, 0x00000004.
- R6: With ID16=1 the data words are the same except for four: 0x00FFAAAA at the first write, 0x00FF5555 at the third, 0x55550000 at the fifth and 0x5555FF00 at the ninth.
- R7: While a write strobe is high and its waitrequest is high, that port's strobe, address and data hold their values into the next cycle. Each script entry is accepted exactly once.
- R8: At most one write is outstanding at a time: the two write strobes are never high together.
- R9: `done_o` rises after the tenth write is accepted and stays high. No further write strobe is raised.
- R10: If either initialization wait lasts INIT_TIMEOUT cycles without both inputs high, `err_o` rises and stays high, and no write is issued. With the defaults the first wait times out 2040 edges after reset release.
- R11: `done_o` and `err_o` are low during reset and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| loc_init_i | input | 1 | Local endpoint reports its port initialized |
| peer_init_i | input | 1 | Peer endpoint reports its port initialized |
| ep_rst_n_o | output | 1 | Shared endpoint reset, active low |
| loc_wr_o | output | 1 | Local master write strobe |
| loc_addr_o | output | ADDR_W | Local master register offset |
| loc_wdata_o | output | 32 | Local master write data |
| loc_wait_i | input | 1 | Local target stalls the current write |
| peer_wr_o | output | 1 | Peer master write strobe |
| peer_addr_o | output | ADDR_W | Peer master register offset |
| peer_wdata_o | output | 32 | Peer master write data |
| peer_wait_i | input | 1 | Peer target stalls the current write |
| done_o | output | 1 | Script finished |
| err_o | output | 1 | Initialization wait timed out |

## Verification
The bench measures the endpoint reset length to the exact edge. A counter off by one, or one that starts at the wrong point, shows up as 39 or 41. It raises only one initialized input, then drops the peer's during the settling interval and holds it low past the interval's end. A design that skips the settle or the second check would start writing early. Both ID widths run side by side against stalling targets, so a swapped address, a mode-dependent word left at its 8-bit value, a dropped stall or a skipped entry shows up in the write log. Timeouts are forced in both waits, and the first one is timed exactly.

// File: rtl/link_bringup_pkg.sv
`timescale 1ns/1ps
package link_bringup_pkg;

  localparam int LB_SCRIPT_LEN = 10;
  localparam int LB_OFS_W      = 20;
  localparam int LB_DATA_W     = 32;

  typedef enum logic [2:0] {
    ST_RST, ST_WAIT1, ST_SETTLE, ST_WAIT2, ST_WRITE, ST_DONE, ST_ERR
  } lb_state_e;

  typedef enum logic {TGT_LOC = 1'b0, TGT_PEER = 1'b1} lb_tgt_e;

  typedef struct packed {
    lb_tgt_e               tgt;
    logic [LB_OFS_W-1:0]   ofs;
    logic [LB_DATA_W-1:0]  data;
  } lb_wr_t;

  // Fixed programming script; four words depend on the device ID width.
  function automatic lb_wr_t lb_script(input logic [3:0] idx, input logic id16);
    lb_wr_t e;
    case (idx)
      4'd0:    e = '{TGT_LOC,  20'h00060, id16 ? 32'h00FF_AAAA : 32'h00AA_FFFF};
      4'd1:    e = '{TGT_LOC,  20'h0013C, 32'h6000_0000};
      4'd2:    e = '{TGT_PEER, 20'h00060, id16 ? 32'h00FF_5555 : 32'h0055_FFFF};
      4'd3:    e = '{TGT_PEER, 20'h0013C, 32'h6000_0000};
      4'd4:    e = '{TGT_LOC,  20'h1040C, id16 ? 32'h5555_0000 : 32'h0055_0000};
      4'd5:    e = '{TGT_LOC,  20'h10404, 32'h0000_0004};
      4'd6:    e = '{TGT_PEER, 20'h10504, 32'h0000_000F};
      4'd7:    e = '{TGT_PEER, 20'h10304, 32'h0000_0004};
      4'd8:    e = '{TGT_LOC,  20'h1010C, id16 ? 32'h5555_FF00 : 32'h0055_FF00};
      default: e = '{TGT_LOC,  20'h10104, 32'h0000_0004};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/lb_span_counter.sv
`timescale 1ns/1ps
module lb_span_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != '1)      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lb_mm_writer.sv
`timescale 1ns/1ps
module lb_mm_writer #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          wait_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          ack_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (start_i) begin
      wr_o   <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (wr_o && !wait_i) begin
      wr_o   <= 1'b0;
    end
  end

  assign ack_o = wr_o & ~wait_i;
endmodule

// File: rtl/link_bringup_seq.sv
`timescale 1ns/1ps
module link_bringup_seq
  import link_bringup_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int RESET_NS      = 200,
  parameter int SETTLE_NS     = 5000,
  parameter int INIT_TIMEOUT  = 2000,
  parameter bit ID16          = 1'b0,
  parameter int ADDR_W        = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_init_i,
  input  logic              peer_init_i,
  output logic              ep_rst_n_o,
  output logic              loc_wr_o,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic [31:0]       loc_wdata_o,
  input  logic              loc_wait_i,
  output logic              peer_wr_o,
  output logic [ADDR_W-1:0] peer_addr_o,
  output logic [31:0]       peer_wdata_o,
  input  logic              peer_wait_i,
  output logic              done_o,
  output logic              err_o
);
  localparam int RESET_CYC  = (RESET_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETTLE_CYC = (SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_A      = (RESET_CYC > SETTLE_CYC) ? RESET_CYC : SETTLE_CYC;
  localparam int MAX_CYC    = (MAX_A > INIT_TIMEOUT) ? MAX_A : INIT_TIMEOUT;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int IDX_W      = $clog2(LB_SCRIPT_LEN);

  lb_state_e          state, nxt_state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic               pend, start, ack_sel, both_up;
  lb_wr_t             ent;
  logic [1:0]         start_v, ack_v, wait_v, wr_v;
  logic [ADDR_W-1:0]  addr_v [2];
  logic [31:0]        data_v [2];

  assign both_up = loc_init_i & peer_init_i;
  assign ent     = lb_script(4'(idx), ID16);

  always_comb begin
    nxt_state = state;
    unique case (state)
      ST_RST:    if (cnt == CNT_W'(RESET_CYC - 1)) nxt_state = ST_WAIT1;
      ST_WAIT1:  if (both_up) nxt_state = ST_SETTLE;
                 else if (cnt == CNT_W'(INIT_TIMEOUT - 1)) nxt_state = ST_ERR;
      ST_SETTLE: if (cnt == CNT_W'(SETTLE_CYC - 1)) nxt_state = ST_WAIT2;
      ST_WAIT2:  if (both_up) nxt_state = ST_WRITE;
                 else if (cnt == CNT_W'(INIT_TIMEOUT - 1)) nxt_state = ST_ERR;
      ST_WRITE:  if (pend && ack_sel && idx == IDX_W'(LB_SCRIPT_LEN - 1)) nxt_state = ST_DONE;
      default:   nxt_state = state;
    endcase
  end

  lb_span_counter #(.CW(CNT_W)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (nxt_state != state),
    .cnt_o (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RST;
      pend  <= 1'b0;
      idx   <= '0;
    end else begin
      state <= nxt_state;
      if (state == ST_WRITE) begin
        if (!pend) begin
          pend <= 1'b1;
        end else if (ack_sel) begin
          pend <= 1'b0;
          idx  <= idx + 1'b1;
        end
      end
    end
  end

  assign start = (state == ST_WRITE) && !pend;

  always_comb begin
    start_v = '0;
    start_v[int'(ent.tgt)] = start;
  end
  assign ack_sel = ack_v[int'(ent.tgt)];
  assign wait_v  = {peer_wait_i, loc_wait_i};

  for (genvar g = 0; g < 2; g++) begin : g_port
    lb_mm_writer #(.AW(ADDR_W), .DW(32)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_v[g]),
      .addr_i  (ADDR_W'(ent.ofs)),
      .data_i  (ent.data),
      .wait_i  (wait_v[g]),
      .wr_o    (wr_v[g]),
      .addr_o  (addr_v[g]),
      .data_o  (data_v[g]),
      .ack_o   (ack_v[g])
    );
  end

  assign loc_wr_o     = wr_v[0];
  assign loc_addr_o   = addr_v[0];
  assign loc_wdata_o  = data_v[0];
  assign peer_wr_o    = wr_v[1];
  assign peer_addr_o  = addr_v[1];
  assign peer_wdata_o = data_v[1];

  assign ep_rst_n_o = (state != ST_RST);
  assign done_o     = (state == ST_DONE);
  assign err_o      = (state == ST_ERR);
endmodule

// File: rtl/link_bringup_seq_chk.sv
`timescale 1ns/1ps
module link_bringup_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ep_rst_n_o,
  input logic              loc_wr_o,
  input logic [ADDR_W-1:0] loc_addr_o,
  input logic [31:0]       loc_wdata_o,
  input logic              loc_wait_i,
  input logic              peer_wr_o,
  input logic [ADDR_W-1:0] peer_addr_o,
  input logic [31:0]       peer_wdata_o,
  input logic              peer_wait_i,
  input logic              done_o,
  input logic              err_o
);
  // R8
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_wr_o && peer_wr_o));
  // R7
  loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr_o && loc_wait_i) |=> (loc_wr_o && $stable(loc_addr_o) && $stable(loc_wdata_o)));
  // R7
  peer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_wr_o && peer_wait_i) |=> (peer_wr_o && $stable(peer_addr_o) && $stable(peer_wdata_o)));
  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !loc_wr_o && !peer_wr_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && !loc_wr_o && !peer_wr_o));
  // R1
  ep_rst_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_rst_n_o |=> ep_rst_n_o);
  // R2
  wr_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr_o || peer_wr_o) |-> ep_rst_n_o);
endmodule

bind link_bringup_seq link_bringup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ep_rst_n_o   (ep_rst_n_o),
  .loc_wr_o     (loc_wr_o),
  .loc_addr_o   (loc_addr_o),
  .loc_wdata_o  (loc_wdata_o),
  .loc_wait_i   (loc_wait_i),
  .peer_wr_o    (peer_wr_o),
  .peer_addr_o  (peer_addr_o),
  .peer_wdata_o (peer_wdata_o),
  .peer_wait_i  (peer_wait_i),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/link_bringup_seq_tb.sv
`timescale 1ns/1ps
module link_bringup_seq_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, li, pi, lw, pw;
  logic a_ep, a_lwr, a_pwr, a_done, a_err;
  logic b_ep, b_lwr, b_pwr, b_done, b_err;
  logic [19:0] a_la, a_pa, b_la, b_pa;
  logic [31:0] a_ld, a_pd, b_ld, b_pd;

  link_bringup_seq #(.ID16(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .loc_init_i(li), .peer_init_i(pi), .ep_rst_n_o(a_ep),
    .loc_wr_o(a_lwr), .loc_addr_o(a_la), .loc_wdata_o(a_ld), .loc_wait_i(lw),
    .peer_wr_o(a_pwr), .peer_addr_o(a_pa), .peer_wdata_o(a_pd), .peer_wait_i(pw),
    .done_o(a_done), .err_o(a_err));

  link_bringup_seq #(.ID16(1'b1)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .loc_init_i(li), .peer_init_i(pi), .ep_rst_n_o(b_ep),
    .loc_wr_o(b_lwr), .loc_addr_o(b_la), .loc_wdata_o(b_ld), .loc_wait_i(lw),
    .peer_wr_o(b_pwr), .peer_addr_o(b_pa), .peer_wdata_o(b_pd), .peer_wait_i(pw),
    .done_o(b_done), .err_o(b_err));

  // {target(1: peer), offset(20), data 8-bit mode(32), data 16-bit mode(32)}
  localparam logic [84:0] VEC [0:9] = '{
    {1'b0, 20'h00060, 32'h00AA_FFFF, 32'h00FF_AAAA},
    {1'b0, 20'h0013C, 32'h6000_0000, 32'h6000_0000},
    {1'b1, 20'h00060, 32'h0055_FFFF, 32'h00FF_5555},
    {1'b1, 20'h0013C, 32'h6000_0000, 32'h6000_0000},
    {1'b0, 20'h1040C, 32'h0055_0000, 32'h5555_0000},
    {1'b0, 20'h10404, 32'h0000_0004, 32'h0000_0004},
    {1'b1, 20'h10504, 32'h0000_000F, 32'h0000_000F},
    {1'b1, 20'h10304, 32'h0000_0004, 32'h0000_0004},
    {1'b0, 20'h1010C, 32'h0055_FF00, 32'h5555_FF00},
    {1'b0, 20'h10104, 32'h0000_0004, 32'h0000_0004}};

  int total = 0, bad = 0;
  int a_n = 0, b_n = 0, hold_bad = 0, both_bad = 0;
  logic [52:0] a_log [16];
  logic [52:0] b_log [16];
  int cyc = 0;
  logic p_lwr = 0, p_lw = 0, p_pwr = 0, p_pw = 0;
  logic [19:0] p_la = '0, p_pa = '0;
  logic [31:0] p_ld = '0, p_pd = '0;

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // slave model: stall pattern, transfer log, hold and overlap tracking
  always @(negedge clk) begin
    if (!rst_n) begin
      a_n = 0; b_n = 0; p_lwr = 0; p_pwr = 0;
      lw = 1'b0; pw = 1'b0;
    end else begin
      if (p_lwr && p_lw && !(a_lwr && a_la == p_la && a_ld == p_ld)) hold_bad++;
      if (p_pwr && p_pw && !(a_pwr && a_pa == p_pa && a_pd == p_pd)) hold_bad++;
      if ((a_lwr && a_pwr) || (b_lwr && b_pwr)) both_bad++;
      cyc++;
      lw = (cyc % 4) != 0;
      pw = ((cyc / 4) % 2) == 1;
      if (a_lwr && !lw && a_n < 16) begin a_log[a_n] = {1'b0, a_la, a_ld}; a_n++; end
      if (a_pwr && !pw && a_n < 16) begin a_log[a_n] = {1'b1, a_pa, a_pd}; a_n++; end
      if (b_lwr && !lw && b_n < 16) begin b_log[b_n] = {1'b0, b_la, b_ld}; b_n++; end
      if (b_pwr && !pw && b_n < 16) begin b_log[b_n] = {1'b1, b_pa, b_pd}; b_n++; end
      p_lwr = a_lwr; p_lw = lw; p_la = a_la; p_ld = a_ld;
      p_pwr = a_pwr; p_pw = pw; p_pa = a_pa; p_pd = a_pd;
    end
  end

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    rst_n = 1'b0; li = 1'b0; pi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 endpoint reset low in system reset", a_ep == 0 && b_ep == 0, a_ep, 0);
    chk("R11 flags low in reset", {a_done, a_err, b_done, b_err} == 0, {a_done, a_err}, 0);

    // length of endpoint reset after release
    rst_n = 1'b1;
    n = 0;
    while (a_ep == 1'b0 && n < 100) begin @(negedge clk); n++; end
    chk("R1 endpoint reset edges after release", n == 40 && b_ep, n, 40);

    repeat (100) @(negedge clk);
    chk("R2 no write with neither init", a_n == 0 && b_n == 0 && !a_lwr && !a_pwr, a_n, 0);
    li = 1'b1;
    repeat (50) @(negedge clk);
    chk("R2 no write with local init only", a_n == 0 && b_n == 0 && !a_lwr && !a_pwr, a_n, 0);
    pi = 1'b1;
    repeat (500) @(negedge clk);
    chk("R3 no write inside settle", a_n == 0 && !a_lwr && !a_pwr, a_n, 0);
    pi = 1'b0;
    repeat (700) @(negedge clk);
    chk("R3 second check holds writes back", a_n == 0 && b_n == 0 && !a_lwr && !a_pwr, a_n, 0);
    chk("R10 no timeout yet", !a_err && !b_err, a_err, 0);
    pi = 1'b1;
    n = 0;
    while (!(a_done && b_done) && n < 500) begin @(negedge clk); n++; end
    chk("R9 done after script", a_done && b_done, {a_done, b_done}, 2'b11);

    for (int i = 0; i < 10; i++) begin
      chk($sformatf("R4 R5 8-bit entry %0d", i),
          a_log[i] == {VEC[i][84:32]}, a_log[i], VEC[i][84:32]);
      chk($sformatf("R4 R6 16-bit entry %0d", i),
          b_log[i] == {VEC[i][84:64], VEC[i][31:0]}, b_log[i], {VEC[i][84:64], VEC[i][31:0]});
    end
    chk("R7 each entry accepted once", a_n == 10 && b_n == 10, a_n, 10);
    repeat (50) @(negedge clk);
    chk("R9 no writes after done", a_n == 10 && b_n == 10 && !a_lwr && !a_pwr && a_done, a_n, 10);
    chk("R7 strobe and payload held under stall", hold_bad == 0, hold_bad, 0);
    chk("R8 single outstanding write", both_bad == 0, both_bad, 0);
    chk("R11 err low with done", !a_err && !b_err, a_err, 0);

    // timeout in the first wait
    rst_n = 1'b0; li = 1'b0; pi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!a_err && n < 5000) begin @(negedge clk); n++; end
    chk("R10 first wait timeout edges", n == 2040 && b_err, n, 2040);
    chk("R10 R11 no writes, done low on timeout", a_n == 0 && !a_done && !b_done, a_n, 0);
    li = 1'b1; pi = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 error sticky after late init", a_err && a_n == 0, a_err, 1);

    // timeout in the second wait
    rst_n = 1'b0; li = 1'b0; pi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    li = 1'b1; pi = 1'b1;
    repeat (300) @(negedge clk);
    li = 1'b0; pi = 1'b0;
    repeat (3200) @(negedge clk);
    chk("R10 second wait timeout", a_err && b_err && !a_done && a_n == 0 && b_n == 0,
        {a_err, b_err}, 2'b11);
    summary();
  end
endmodule